// File: doc/BRIEF.md
# SPI Activity Watchdog

This block supervises a host that talks to the chip over SPI. Once armed, it counts ticks of a 3.6864 MHz timebase, presented as a one-cycle clock enable. Every valid frame reported by the SPI front end starts the count again from zero. If the count reaches the selected period with no frame, the block raises a one-cycle timeout event and a sticky timeout flag. It then stays idle until a new frame or a status clear.

The period comes from a 3-bit code held in the block's own configuration flops. The eight codes span 50 ms to 5 s. The code and the arm bit are written through separate strobes. The arm bit comes out of reset clear, and the code comes out of reset at the 2 s setting. A code written during a count is latched only when the count next restarts. The `TICK_HZ` parameter sets the tick rate; the terminal counts and the counter width are derived from it.

Top module: `spi_wdt`

## Requirements
- R1: After reset, `timeout_o` and `timeout_evt_o` are low, the watchdog is disarmed and the period code is 3'b100.
- R2: While disarmed, ticks and `frame_i` strobes produce no event and never set the flag.
- R3: The terminal count for a code is TICK_HZ times its period. At the default rate this is 184,320 ticks for 50 ms up to 18,432,000 ticks for 5 s. `timeout_evt_o` is high in the cycle after the edge that takes the tick completing the count, where counting starts at the edge after the restart edge.
- R4: Code 3'b000 selects 50 ms, 3'b001 selects 100 ms, 3'b010 selects 500 ms and 3'b011 selects 1 s.
- R5: Code 3'b100 selects 2 s, 3'b101 selects 3 s, 3'b110 selects 4 s and 3'b111 selects 5 s. Arming after reset without writing a code gives 2 s.
- R6: A `frame_i` strobe while armed restarts the count from zero.
- R7: On reaching the terminal count, `timeout_evt_o` pulses for exactly one cycle and `timeout_o` rises in the same cycle. The flag stays high, and counting halts until a frame or a clear.
- R8: A `clr_i` strobe drops `timeout_o` in the next cycle and restarts the count from zero.
- R9: Disarming zeroes the count at once with no event. Re-arming later times a full period.
- R10: A code written during a count takes effect only at the next restart (a frame, a clear or arming).
- R11: The count advances only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase clock enable, one cycle per tick |
| sel_we_i | input | 1 | Write strobe for the period code |
| sel_wdata_i | input | 3 | New period code |
| en_we_i | input | 1 | Write strobe for the arm bit |
| en_wdata_i | input | 1 | New arm bit value |
| frame_i | input | 1 | Valid SPI frame received, one-cycle strobe |
| clr_i | input | 1 | Clear the timeout flag and restart the count |
| timeout_o | output | 1 | Sticky timeout flag |
| timeout_evt_o | output | 1 | One-cycle timeout event |

## Verification
A wrong count, a latched limit loaded at the wrong moment, or a halt state that never releases shows at the ports only as an event that comes early, comes late or never comes. The error can therefore stay hidden for a whole period, up to the longest terminal count. To keep that delay short, the bench runs the block at a reduced tick rate. It measures the number of ticks from each restart to the event for every code and for each kind of restart, and it compares both outputs with a reference model on every clock. A flag that fails to clear or to stick differs from the model one cycle after the stimulus.

// File: rtl/spi_wdt_pkg.sv
package spi_wdt_pkg;

  localparam int unsigned SEL_W   = 3;
  localparam int unsigned NUM_SEL = 1 << SEL_W;
  localparam logic [SEL_W-1:0] SEL_RST = 3'b100;

  function automatic longint unsigned period_ms(input int unsigned code);
    case (code)
      0:       return 64'd50;
      1:       return 64'd100;
      2:       return 64'd500;
      3:       return 64'd1000;
      4:       return 64'd2000;
      5:       return 64'd3000;
      6:       return 64'd4000;
      default: return 64'd5000;
    endcase
  endfunction

  function automatic longint unsigned term_ticks(input longint unsigned hz,
                                                 input int unsigned code);
    return (hz * period_ms(code)) / 64'd1000;
  endfunction

endpackage

// File: rtl/spi_wdt_cfg.sv
module spi_wdt_cfg
  import spi_wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_wdata_i,
  input  logic             en_we_i,
  input  logic             en_wdata_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             en_o
);

  logic [SEL_W-1:0] sel_q;
  logic             en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SEL_RST;
      en_q  <= 1'b0;
    end else begin
      if (sel_we_i) sel_q <= sel_wdata_i;
      if (en_we_i)  en_q  <= en_wdata_i;
    end
  end

  assign sel_o = sel_q;
  assign en_o  = en_q;

  // R1
  rst_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (sel_q == SEL_RST) && !en_q);

endmodule

// File: rtl/spi_wdt_lut.sv
module spi_wdt_lut
  import spi_wdt_pkg::*;
#(
  parameter longint unsigned TICK_HZ = 64'd3_686_400,
  parameter int unsigned     CNT_W   = 25
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] lim_o
);

  logic [CNT_W-1:0] tbl [NUM_SEL];

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_ent
    assign tbl[g] = CNT_W'(term_ticks(TICK_HZ, g));
  end

  assign lim_o = tbl[sel_i];

endmodule

// File: rtl/spi_wdt_cnt.sv
module spi_wdt_cnt #(
  parameter int unsigned CNT_W = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             hit_o,
  output logic             evt_o
);

  logic [CNT_W-1:0] cnt_q, lim_q, cnt_inc;
  logic             run_q, evt_q, hit;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    hit = 1'b0;
    if (en_i && !restart_i && run_q && tick_i && (cnt_inc == lim_q)) hit = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
      run_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= hit;
      if (!en_i || restart_i) begin
        // limit latched only here (R10)
        cnt_q <= '0;
        lim_q <= lim_i;
        run_q <= 1'b1;
      end else if (run_q && tick_i) begin
        cnt_q <= cnt_inc;
        if (hit) run_q <= 1'b0;
      end
    end
  end

  assign hit_o = hit;
  assign evt_o = evt_q;

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
  // R6
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && restart_i) |=> (cnt_q == '0));
  // R7
  evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);
  // R9
  dis_no_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!evt_q && cnt_q == '0));
  // R11
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/spi_wdt_flag.sv
module spi_wdt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R8
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/spi_wdt.sv
module spi_wdt
  import spi_wdt_pkg::*;
#(
  parameter longint unsigned TICK_HZ = 64'd3_686_400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sel_we_i,
  input  logic [SEL_W-1:0] sel_wdata_i,
  input  logic             en_we_i,
  input  logic             en_wdata_i,
  input  logic             frame_i,
  input  logic             clr_i,
  output logic             timeout_o,
  output logic             timeout_evt_o
);

  localparam int unsigned CNT_W = $clog2(term_ticks(TICK_HZ, NUM_SEL - 1) + 64'd1);

  logic [SEL_W-1:0] sel;
  logic             en, hit, restart;
  logic [CNT_W-1:0] lim;

  assign restart = frame_i | clr_i;

  spi_wdt_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_we_i    (sel_we_i),
    .sel_wdata_i (sel_wdata_i),
    .en_we_i     (en_we_i),
    .en_wdata_i  (en_wdata_i),
    .sel_o       (sel),
    .en_o        (en)
  );

  spi_wdt_lut #(.TICK_HZ(TICK_HZ), .CNT_W(CNT_W)) u_lut (
    .sel_i (sel),
    .lim_o (lim)
  );

  spi_wdt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .tick_i    (tick_i),
    .restart_i (restart),
    .lim_i     (lim),
    .hit_o     (hit),
    .evt_o     (timeout_evt_o)
  );

  spi_wdt_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (clr_i),
    .flag_o (timeout_o)
  );

  // R7
  evt_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_evt_o |-> timeout_o);
  // R2
  idle_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !timeout_o) |=> !timeout_o);

endmodule

// File: tb/spi_wdt_tb_top.sv
module spi_wdt_tb_top;

  localparam longint unsigned HZ = 64'd2000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       sel_we_i = 1'b0;
  logic [2:0] sel_wdata_i = 3'b000;
  logic       en_we_i = 1'b0;
  logic       en_wdata_i = 1'b0;
  logic       frame_i = 1'b0;
  logic       clr_i = 1'b0;
  logic       timeout_o, timeout_evt_o;

  int    n_run = 0;
  int    n_fail = 0;
  bit    cmp_en = 1'b0;
  string cur_req = "R1";

  always #2 clk_i = ~clk_i;

  spi_wdt #(.TICK_HZ(HZ)) dut_i (
    .clk_i, .rst_ni, .tick_i, .sel_we_i, .sel_wdata_i, .en_we_i,
    .en_wdata_i, .frame_i, .clr_i, .timeout_o, .timeout_evt_o
  );

  function automatic int ref_ticks(input int code);
    int ms;
    case (code)
      0: ms = 50;    1: ms = 100;   2: ms = 500;   3: ms = 1000;
      4: ms = 2000;  5: ms = 3000;  6: ms = 4000;  default: ms = 5000;
    endcase
    return int'(HZ) * ms / 1000;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model
  int m_sel, m_cnt, m_lim;
  bit m_en, m_run, m_evt, m_flag;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_sel = 4; m_en = 0; m_cnt = 0; m_lim = 0; m_run = 0; m_evt = 0; m_flag = 0;
    end else begin
      bit e;
      e = 0;
      if (!m_en || frame_i || clr_i) begin
        m_cnt = 0; m_lim = ref_ticks(m_sel); m_run = 1;
      end else if (m_run && tick_i) begin
        m_cnt++;
        if (m_cnt == m_lim) begin m_run = 0; e = 1; end
      end
      if (e) m_flag = 1; else if (clr_i) m_flag = 0;
      m_evt = e;
      if (sel_we_i) m_sel = int'(sel_wdata_i);
      if (en_we_i)  m_en = en_wdata_i;
    end
  end

  always @(negedge clk_i) begin
    if (cmp_en) begin
      chk({cur_req, " evt"}, timeout_evt_o, m_evt);
      chk({cur_req, " flag"}, timeout_o, m_flag);
    end
  end

  task automatic step(); @(negedge clk_i); endtask
  task automatic wr_sel(input logic [2:0] v);
    sel_wdata_i = v; sel_we_i = 1'b1; step(); sel_we_i = 1'b0;
  endtask
  task automatic wr_en(input logic v);
    en_wdata_i = v; en_we_i = 1'b1; step(); en_we_i = 1'b0;
  endtask
  task automatic pulse_clr(); clr_i = 1'b1; step(); clr_i = 1'b0; endtask
  task automatic pulse_frame(); frame_i = 1'b1; step(); frame_i = 1'b0; endtask

  // ticks delivered from now until the event appears
  task automatic measure(input string req, input int exp_ticks, input int per);
    int got = 0;
    bit seen = 1'b0;
    for (int k = 0; k < exp_ticks * per + 40 && !seen; k++) begin
      tick_i = (k % per == 0);
      if (tick_i) got++;
      step();
      if (timeout_evt_o) seen = 1'b1;
    end
    tick_i = 1'b1;
    chk(req, seen ? got : -1, exp_ticks);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    cmp_en = 1'b1;
    cur_req = "R1";
    chk("R1 flag", timeout_o, 0);
    chk("R1 evt", timeout_evt_o, 0);

    cur_req = "R2";
    for (int i = 0; i < 300; i++) begin
      if (i % 7 == 0) pulse_frame(); else step();
    end
    chk("R2 flag", timeout_o, 0);

    cur_req = "R5";
    wr_en(1'b1);
    measure("R5 default 2s", 4000, 1);
    chk("R7 flag set", timeout_o, 1);

    cur_req = "R7";
    begin
      int evts = 0;
      for (int i = 0; i < 200; i++) begin step(); if (timeout_evt_o) evts++; end
      chk("R7 halted", evts, 0);
      chk("R7 sticky", timeout_o, 1);
    end

    for (int c = 0; c < 8; c++) begin
      cur_req = (c < 4) ? "R3 R4" : "R3 R5";
      wr_sel(c[2:0]);
      pulse_clr();
      chk("R8 clear", timeout_o, 0);
      measure(cur_req, ref_ticks(c), 1);
    end

    cur_req = "R6";
    wr_sel(3'd1);
    pulse_clr();
    repeat (150) step();
    pulse_frame();
    measure("R6 frame restart", 200, 1);

    cur_req = "R10";
    wr_sel(3'd2);
    pulse_clr();
    repeat (100) step();
    wr_sel(3'd0);
    measure("R10 old limit kept", 1000 - 101, 1);
    pulse_clr();
    measure("R10 new limit", 100, 1);

    cur_req = "R9";
    wr_sel(3'd2);
    pulse_clr();
    repeat (300) step();
    wr_en(1'b0);
    begin
      int evts = 0;
      for (int i = 0; i < 1500; i++) begin step(); if (timeout_evt_o) evts++; end
      chk("R9 no evt", evts, 0);
    end
    wr_en(1'b1);
    measure("R9 full period", 1000, 1);

    cur_req = "R11";
    wr_sel(3'd0);
    pulse_clr();
    measure("R11 gated ticks", 100, 3);

    step();
    finish_run();
  end

endmodule